// File: doc/BRIEF.md
# Stereo PDM Capture Deinterleaver

This block receives audio from one or two pulse-density-modulated microphones that share one data wire and one clock. It divides a fast system clock down to make the microphone clock. It then takes one sample of the shared wire after each microphone clock edge. The two microphones take turns on the wire, so the block sorts the samples into a left 1-bit stream and a right 1-bit stream. Each stream has its own one-cycle valid strobe. Decimation and DC filtering happen further downstream.

A clock-enable input stops the microphone clock, which puts the microphones to sleep. The clock is always parked at the low level, and only after a complete high phase. Each time the clock starts, from reset or after a stop, both streams stay silent for a fixed number of microphone clock cycles while the microphones wake up. A mono mode captures one chosen channel and leaves the other stream idle. Software chooses how many system cycles after each edge the wire is sampled.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While reset is asserted, the microphone clock, both valid strobes and both bit outputs are low.
- R2: While enabled, the microphone clock has a period of exactly DIV_RATIO system cycles. Each high phase and each low phase lasts DIV_RATIO/2 system cycles.
- R3: A sample taken after a falling microphone clock edge is a right-channel bit. A sample taken after a rising edge is a left-channel bit. Each sample passes through SYNC_STAGES synchronizer flops and is taken when the edge is `sampleDelay` system cycles old. It appears on `leftBit`/`rightBit` together with a one-cycle valid pulse, in the order the bits were launched.
- R4: In stereo mode, each microphone clock period yields exactly one left and one right sample. The two valid strobes are never high in the same cycle. A left valid occurs only while the microphone clock is high, and a right valid only while it is low.
- R5: After the clock starts, no valid strobe fires until WAKE_CYCLES rising edges have occurred. The first valid is the left sample that follows rising edge number WAKE_CYCLES.
- R6: When `clkEn` is low, no new rising edge is produced. A high phase already in progress finishes at its full length, and the clock then stays low.
- R7: Restarting the clock after it has been parked restarts the start-up blanking window of R5 from zero.
- R8: With `monoEn` high, only the channel chosen by `monoSelLeft` (1 = left, 0 = right) produces valid strobes. The other valid strobe stays low.
- R9: A `sampleDelay` larger than DIV_RATIO/2 - 2 is treated as DIV_RATIO/2 - 2, so every sample and its valid strobe land within the same half period as their edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Enables the microphone clock; low parks it low (sleep) |
| monoEn | input | 1 | 1 = capture a single channel |
| monoSelLeft | input | 1 | In mono mode, 1 selects left, 0 selects right |
| sampleDelay | input | DLY_W | System cycles from a clock edge to its sample point |
| micData | input | 1 | Shared PDM data wire from the microphones |
| micClk | output | 1 | Generated microphone clock |
| leftBit | output | 1 | Latest left-channel bit |
| leftValid | output | 1 | One-cycle strobe: new left bit |
| rightBit | output | 1 | Latest right-channel bit |
| rightValid | output | 1 | One-cycle strobe: new right bit |

## Verification
The assertions check, on every cycle, the following timing properties:
- the length of each high phase, and that no rise comes before a full low phase;
- that the clock stays low whenever the enable is low;
- that the two strobes are exclusive, and that each falls in its own half period;
- that nothing is valid before the wake-up count of rising edges;
- mono-mode silencing of the unselected channel.

Only the bench scenarios can show that the right bits come out, in order, on the right channel. The bench does this by driving bits the way two microphones would and comparing them through a scoreboard, across several sample delays including a clamped one. The bench scenarios also show that a restart re-blanks the output, and that every launched bit after the window is delivered, with none lost or duplicated.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

  // Capture requests issued by the control to the datapath.
  typedef struct packed {
    logic captureLeft;
    logic captureRight;
  } pdm_strobe_t;

endpackage

// File: rtl/pdm_rx_ctrl.sv
module pdm_rx_ctrl
  import pdm_rx_pkg::*;
#(
  parameter int DIV_RATIO   = 20,
  parameter int WAKE_CYCLES = 32768,
  parameter int DLY_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             monoEn,
  input  logic             monoSelLeft,
  input  logic [DLY_W-1:0] sampleDelay,
  output logic             micClk,
  output pdm_strobe_t      strobe
);

  localparam int HALF    = DIV_RATIO / 2;
  localparam int CNT_W   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int MAX_DLY = HALF - 2;
  localparam int WAKE_W  = $clog2(WAKE_CYCLES + 1);

  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0]  MAX_DLY_C = CNT_W'(MAX_DLY);
  localparam logic [DLY_W-1:0]  MAX_DLY_D = DLY_W'(MAX_DLY);
  localparam logic [WAKE_W-1:0] WAKE_DONE = WAKE_W'(WAKE_CYCLES);

  logic [CNT_W-1:0]  divCnt;
  logic              micClkQ;
  logic              armed;
  logic [WAKE_W-1:0] wakeCnt;

  logic              terminal;
  logic              riseNow;
  logic              fallNow;
  logic              parkNow;
  logic              sampleNow;
  logic              ready;
  logic              leftOn;
  logic              rightOn;
  logic [CNT_W-1:0]  effDelay;

  // Sample point, clamped so the capture stays inside the current half period.
  always_comb begin
    if (sampleDelay > MAX_DLY_D) effDelay = MAX_DLY_C;
    else                         effDelay = CNT_W'(sampleDelay);
  end

  always_comb begin
    terminal  = (divCnt == LAST_CNT);
    riseNow   = terminal && !micClkQ && clkEn;
    fallNow   = terminal && micClkQ;
    parkNow   = terminal && !micClkQ && !clkEn;
    sampleNow = armed && (divCnt == effDelay);
    ready     = (wakeCnt == WAKE_DONE);
    leftOn    = !monoEn || monoSelLeft;
    rightOn   = !monoEn || !monoSelLeft;
  end

  // Half-period counter and clock level; a rise is only allowed while enabled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      micClkQ <= 1'b0;
    end else begin
      divCnt <= terminal ? '0 : divCnt + 1'b1;
      if (riseNow)      micClkQ <= 1'b1;
      else if (fallNow) micClkQ <= 1'b0;
    end
  end

  // One pending sample per edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  armed <= 1'b0;
    else if (riseNow || fallNow) armed <= 1'b1;
    else if (sampleNow)          armed <= 1'b0;
  end

  // Start-up blanking: count rising edges; a suppressed rise means the clock is parked.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      wakeCnt <= '0;
    else if (parkNow)               wakeCnt <= '0;
    else if (riseNow && !ready)     wakeCnt <= wakeCnt + 1'b1;
  end

  always_comb begin
    strobe.captureLeft  = sampleNow && micClkQ  && ready && leftOn;
    strobe.captureRight = sampleNow && !micClkQ && ready && rightOn;
  end

  assign micClk = micClkQ;

endmodule

// File: rtl/pdm_rx_datapath.sv
module pdm_rx_datapath
  import pdm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        micData,
  input  pdm_strobe_t strobe,
  output logic        leftBit,
  output logic        leftValid,
  output logic        rightBit,
  output logic        rightValid
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineNow;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= micData;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], micData};
      end
    end
  endgenerate

  assign lineNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftBit    <= 1'b0;
      leftValid  <= 1'b0;
      rightBit   <= 1'b0;
      rightValid <= 1'b0;
    end else begin
      leftValid  <= strobe.captureLeft;
      rightValid <= strobe.captureRight;
      if (strobe.captureLeft)  leftBit  <= lineNow;
      if (strobe.captureRight) rightBit <= lineNow;
    end
  end

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
  import pdm_rx_pkg::*;
#(
  parameter int DIV_RATIO   = 20,
  parameter int WAKE_CYCLES = 32768,
  parameter int DLY_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             monoEn,
  input  logic             monoSelLeft,
  input  logic [DLY_W-1:0] sampleDelay,
  input  logic             micData,
  output logic             micClk,
  output logic             leftBit,
  output logic             leftValid,
  output logic             rightBit,
  output logic             rightValid
);

  pdm_strobe_t strobe;

  pdm_rx_ctrl #(
    .DIV_RATIO  (DIV_RATIO),
    .WAKE_CYCLES(WAKE_CYCLES),
    .DLY_W      (DLY_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkEn      (clkEn),
    .monoEn     (monoEn),
    .monoSelLeft(monoSelLeft),
    .sampleDelay(sampleDelay),
    .micClk     (micClk),
    .strobe     (strobe)
  );

  pdm_rx_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .micData   (micData),
    .strobe    (strobe),
    .leftBit   (leftBit),
    .leftValid (leftValid),
    .rightBit  (rightBit),
    .rightValid(rightValid)
  );

endmodule

// File: rtl/pdm_stereo_rx_chk.sv
module pdm_stereo_rx_chk #(
  parameter int DIV_RATIO   = 20,
  parameter int WAKE_CYCLES = 32768
) (
  input logic clk,
  input logic rstN,
  input logic clkEn,
  input logic monoEn,
  input logic monoSelLeft,
  input logic micClk,
  input logic leftBit,
  input logic leftValid,
  input logic rightBit,
  input logic rightValid
);

  localparam int HALF   = DIV_RATIO / 2;
  localparam int RISE_W = $clog2(WAKE_CYCLES + 1);

  logic              prevClk;
  logic [15:0]       runLen;
  logic [RISE_W-1:0] riseCnt;

  // Length of the current clock level and rising edges since the clock last started.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      runLen  <= '0;
      riseCnt <= '0;
    end else begin
      prevClk <= micClk;
      if (micClk != prevClk)  runLen <= 16'd1;
      else if (runLen != '1)  runLen <= runLen + 1'b1;
      if (!micClk && int'(runLen) > HALF)
        riseCnt <= '0;
      else if (micClk && !prevClk && int'(riseCnt) < WAKE_CYCLES)
        riseCnt <= riseCnt + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!micClk && !leftValid && !rightValid && !leftBit && !rightBit));

  // R2
  high_phase_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(micClk) |-> (int'(runLen) == HALF));

  // R2
  low_phase_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(micClk) |-> (int'(runLen) >= HALF));

  // R6
  parked_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!micClk && !clkEn) |=> !micClk);

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leftValid && rightValid));

  // R4
  left_in_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    leftValid |-> micClk);

  // R4
  right_in_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    rightValid |-> !micClk);

  // R5
  wake_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftValid || rightValid) |-> (int'(riseCnt) >= WAKE_CYCLES));

  // R8
  mono_left_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (monoEn && monoSelLeft) |-> !rightValid);

  // R8
  mono_right_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (monoEn && !monoSelLeft) |-> !leftValid);

endmodule

bind pdm_stereo_rx pdm_stereo_rx_chk #(
  .DIV_RATIO  (DIV_RATIO),
  .WAKE_CYCLES(WAKE_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clkEn      (clkEn),
  .monoEn     (monoEn),
  .monoSelLeft(monoSelLeft),
  .micClk     (micClk),
  .leftBit    (leftBit),
  .leftValid  (leftValid),
  .rightBit   (rightBit),
  .rightValid (rightValid)
);

// File: tb/pdm_stereo_rx_bench.sv
module pdm_stereo_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 16;
  localparam int HALF       = DIV / 2;
  localparam int WAKE       = 20;
  localparam int DLY_W      = 5;
  localparam int RUN        = 40;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             clkEn = 1'b0;
  logic             monoEn = 1'b0;
  logic             monoSelLeft = 1'b0;
  logic [DLY_W-1:0] sampleDelay = 5'd4;
  logic             micData = 1'b0;
  logic             micClk;
  logic             leftBit;
  logic             leftValid;
  logic             rightBit;
  logic             rightValid;

  int    testsRun = 0;
  int    testsFailed = 0;
  int    riseCount = 0;
  int    leftSeen = 0;
  int    rightSeen = 0;
  int    cyc = 0;
  string phaseTag = "R5";
  bit    leftQ[$];
  bit    rightQ[$];

  int kL, kR;
  bit bL, bR, expL, expR;

  pdm_stereo_rx #(
    .DIV_RATIO  (DIV),
    .WAKE_CYCLES(WAKE),
    .DLY_W      (DLY_W),
    .SYNC_STAGES(2)
  ) u_pdm_stereo_rx (
    .clk        (clk),
    .rstN       (rstN),
    .clkEn      (clkEn),
    .monoEn     (monoEn),
    .monoSelLeft(monoSelLeft),
    .sampleDelay(sampleDelay),
    .micData    (micData),
    .micClk     (micClk),
    .leftBit    (leftBit),
    .leftValid  (leftValid),
    .rightBit   (rightBit),
    .rightValid (rightValid)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Left microphone model: launches a bit shortly after each rising edge.
  initial forever begin
    @(posedge micClk);
    riseCount++;
    kL = riseCount;
    @(posedge clk); #1;
    if (!monoEn || monoSelLeft) begin
      bL = 1'($urandom);
      micData = bL;
      if (kL >= WAKE) leftQ.push_back(bL);
    end
  end

  // Right microphone model: launches a bit shortly after each falling edge.
  initial forever begin
    @(negedge micClk);
    kR = riseCount;
    @(posedge clk); #1;
    if (!monoEn || !monoSelLeft) begin
      bR = 1'($urandom);
      micData = bR;
      if (kR >= WAKE) rightQ.push_back(bR);
    end
  end

  // Scoreboard monitor, sampling away from the active edge.
  initial forever begin
    @(negedge clk);
    if (leftValid) begin
      leftSeen++;
      if (leftQ.size() == 0) check(1'b0, phaseTag, "unexpected left valid", 1, 0);
      else begin
        expL = leftQ.pop_front();
        check(leftBit == expL, "R3", "left bit", int'(leftBit), int'(expL));
      end
    end
    if (rightValid) begin
      rightSeen++;
      if (rightQ.size() == 0) check(1'b0, phaseTag, "unexpected right valid", 1, 0);
      else begin
        expR = rightQ.pop_front();
        check(rightBit == expR, "R3", "right bit", int'(rightBit), int'(expR));
      end
    end
  end

  task automatic measureClock();
    int t0, t1, t2;
    @(posedge micClk); t0 = cyc;
    @(negedge micClk); t1 = cyc;
    @(posedge micClk); t2 = cyc;
    check((t1 - t0) == HALF, "R2", "high phase cycles", t1 - t0, HALF);
    check((t2 - t0) == DIV, "R2", "period cycles", t2 - t0, DIV);
  endtask

  task automatic stopClock();
    @(negedge micClk);
    repeat (2) @(posedge clk);
    #1;
    clkEn = 1'b0;
    riseCount = 0;
    repeat (DIV) @(posedge clk);
    #1;
  endtask

  task automatic runPhase(input string tag, input int dly, input bit mono,
                          input bit selLeft, input bit measure);
    monoEn = mono;
    monoSelLeft = selLeft;
    sampleDelay = DLY_W'(dly);
    leftSeen = 0;
    rightSeen = 0;
    phaseTag = tag;
    @(posedge clk); #1;
    clkEn = 1'b1;
    wait (riseCount >= WAKE);
    check((leftSeen + rightSeen) == 0, tag, "valids inside start-up window",
          leftSeen + rightSeen, 0);
    if (measure) measureClock();
    wait (riseCount >= WAKE + RUN);
    stopClock();
    check(leftQ.size() == 0, "R3", "left bits left undelivered", leftQ.size(), 0);
    check(rightQ.size() == 0, "R3", "right bits left undelivered", rightQ.size(), 0);
    repeat (4 * DIV) @(posedge clk);
    #1;
    check(riseCount == 0 && micClk == 1'b0, "R6", "rises while parked", riseCount, 0);
    if (!mono) begin
      check(leftSeen >= RUN, "R4", "left samples in stereo run", leftSeen, RUN);
      check((leftSeen - rightSeen) <= 1 && (rightSeen - leftSeen) <= 1, "R4",
            "left/right sample balance", leftSeen - rightSeen, 0);
    end else if (selLeft) begin
      check(rightSeen == 0, "R8", "right valids in mono-left", rightSeen, 0);
      check(leftSeen >= RUN, "R8", "left samples in mono-left", leftSeen, RUN);
    end else begin
      check(leftSeen == 0, "R8", "left valids in mono-right", leftSeen, 0);
      check(rightSeen >= RUN, "R8", "right samples in mono-right", rightSeen, RUN);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(micClk == 1'b0, "R1", "micClk in reset", int'(micClk), 0);
    check(!leftValid && !rightValid, "R1", "valids in reset",
          int'(leftValid) + int'(rightValid), 0);
    check(!leftBit && !rightBit, "R1", "bits in reset", int'(leftBit) + int'(rightBit), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(micClk == 1'b0, "R6", "clock idle with clkEn low", int'(micClk), 0);

    runPhase("R5", 4, 1'b0, 1'b0, 1'b1);   // stereo, first start after reset
    runPhase("R7", 6, 1'b0, 1'b0, 1'b1);   // restart re-blanks, latest legal delay
    runPhase("R9", 15, 1'b0, 1'b0, 1'b0);  // oversized delay is clamped
    runPhase("R8", 4, 1'b1, 1'b1, 1'b0);   // mono, left selected
    runPhase("R8", 5, 1'b1, 1'b0, 1'b0);   // mono, right selected
    runPhase("R7", 3, 1'b0, 1'b0, 1'b0);   // earliest delay, another restart

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule